// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block collects eight interrupt request lines and turns them into one interrupt output toward a processor, plus an 8-bit vector that is returned when the processor acknowledges. It keeps three 8-bit registers: a request register, a mask register and an in-service register. Priority is fixed, with line 0 the highest. The interrupt output is raised when the best unmasked request outranks everything already in service.

Software reaches the block through a small register window. One address takes commands. The next takes the mask and the configuration words. A third address holds the per-line trigger type. A command byte of 0x11 opens a configuration sequence, and the next three writes to the data address fill, in order, the vector base, the cascade word and the mode word. After that, the command address also accepts specific end-of-interrupt commands and a choice of which register a command-address read returns. The mode word can turn on auto-EOI. An acknowledge that finds no valid request returns the vector of line 7 and changes nothing else.

Top module: `pvic_top`

## Requirements
- R1: After reset the mask reads 0xFF, the request, in-service and trigger registers read 0x00, command-address reads select the request register, the vector output is 0x00 and the interrupt output is low.
- R2: A command write of 0x11 starts configuration. The next three data-address writes load the vector base (bits 7:3 kept, bits 2:0 dropped), then the cascade word, then the mode word. None of the three changes the mask. Starting configuration also clears the in-service register and selects request readback.
- R3: An acknowledge granted to line n registers vector {base, n}, which appears on the vector output in the cycle after the acknowledge strobe.
- R4: With the role input low (master), the cascade-mask output equals the cascade word and the slave-identity output is 0. With the role input high (slave), the slave-identity output is cascade-word bits 2:0 and the cascade-mask output is 0.
- R5: When mode-word bit 1 is set (auto-EOI), a granted acknowledge sets no in-service bit.
- R6: A command write of 0x60+n (n in 0..7) clears in-service bit n and no other bit.
- R7: A command write of 0x0A selects the request register and 0x0B selects the in-service register for later command-address reads, until the next such command. Data-address reads return the mask and address 2 reads return the trigger register.
- R8: Outside configuration, a data-address write loads the mask. A mask bit of 1 blocks that line from raising the interrupt output, while its request is still recorded.
- R9: Trigger bit n = 0 makes line n edge-triggered: a rising edge sets its request, which then holds until that line is acknowledged, whatever the line does afterwards. Trigger bit n = 1 makes it level-triggered: its request follows the line.
- R10: The interrupt output is high exactly when the lowest-numbered unmasked request has a lower index than every set in-service bit.
- R11: A granted acknowledge without auto-EOI sets the winner's in-service bit and clears its edge-latched request.
- R12: An acknowledge while the interrupt output is low returns vector {base, 7} and leaves the in-service register and the request latches unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, bit n is line n |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | 0 = command, 1 = data/mask, 2 = trigger type |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ack | input | 1 | Single-cycle interrupt acknowledge strobe |
| is_slave | input | 1 | Role select: 0 master, 1 slave |
| int_out | output | 1 | Interrupt output to the processor |
| vec_out | output | 8 | Vector registered at the last acknowledge |
| casc_mask | output | 8 | Lines with a slave attached (master role) |
| slave_id | output | 3 | Master line this unit hangs on (slave role) |

## Verification
The assertions take for granted that software does not send an end-of-interrupt for the line that is being acknowledged in the same cycle, and that it issues end-of-interrupt only for lines that are in service. The random stimulus follows both rules: it sends end-of-interrupt only in cycles without an acknowledge, and only for the lowest set in-service bit of the bench's own model. The line toggles are sparse, and the trigger and mask values are fixed and mixed, so edge latching, level following, masking and priority blocking all occur together.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int LINES  = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int DW     = 8;
  localparam int BASE_W = DW - IDX_W;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_TRIG = 2'd2;

  localparam logic [DW-1:0]     CMD_INIT    = 8'h11;
  localparam logic [DW-1:0]     CMD_SEL_IRR = 8'h0A;
  localparam logic [DW-1:0]     CMD_SEL_ISR = 8'h0B;
  localparam logic [BASE_W-1:0] CMD_EOI_TAG = 5'b01100;
  localparam int                MODE_AEOI_BIT = 1;
  localparam logic [IDX_W-1:0]  SPUR_IDX = IDX_W'(LINES - 1);

  typedef enum logic [1:0] {
    CFG_READY,
    CFG_WAIT_BASE,
    CFG_WAIT_CASC,
    CFG_WAIT_MODE
  } cfg_state_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } pick_t;

  // lowest-numbered set bit wins
  function automatic pick_t pick_first(input logic [LINES-1:0] v);
    pick_t p;
    p = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.hit = 1'b1;
        p.idx = IDX_W'(i);
      end
    end
    return p;
  endfunction

  // true when no in-service bit sits at or above the candidate's priority
  function automatic logic outranks(input logic [IDX_W-1:0] idx,
                                    input logic [LINES-1:0] isr);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LINES; i++) begin
      if (isr[i] && (i <= int'(idx))) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic [LINES-1:0] line_bit(input logic [IDX_W-1:0] idx);
    logic [LINES-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  function automatic logic [DW-1:0] make_vector(input logic [BASE_W-1:0] base,
                                                input logic [IDX_W-1:0] idx);
    return {base, idx};
  endfunction
endpackage

// File: rtl/pvic_cfg.sv
module pvic_cfg
  import pvic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [LINES-1:0]  mask_q,
  output logic [BASE_W-1:0] base_q,
  output logic [DW-1:0]     casc_q,
  output logic              aeoi_q,
  output logic              rd_isr_q,
  output logic [LINES-1:0]  trig_q,
  output logic              eoi_valid,
  output logic [IDX_W-1:0]  eoi_idx,
  output logic              init_start
);
  cfg_state_e state_q;

  logic cmd_wr, data_wr, trig_wr, sel_irr, sel_isr;

  assign cmd_wr     = bus_wr && (bus_addr == ADDR_CMD);
  assign data_wr    = bus_wr && (bus_addr == ADDR_DATA);
  assign trig_wr    = bus_wr && (bus_addr == ADDR_TRIG);
  assign init_start = cmd_wr && (bus_wdata == CMD_INIT);
  assign sel_irr    = cmd_wr && (bus_wdata == CMD_SEL_IRR);
  assign sel_isr    = cmd_wr && (bus_wdata == CMD_SEL_ISR);
  assign eoi_valid  = cmd_wr && (bus_wdata[DW-1:IDX_W] == CMD_EOI_TAG);
  assign eoi_idx    = bus_wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= CFG_READY;
      mask_q   <= '1;
      base_q   <= '0;
      casc_q   <= '0;
      aeoi_q   <= 1'b0;
      rd_isr_q <= 1'b0;
      trig_q   <= '0;
    end else begin
      if (trig_wr) trig_q <= bus_wdata[LINES-1:0];
      if (init_start) begin
        state_q  <= CFG_WAIT_BASE;
        rd_isr_q <= 1'b0;
      end else begin
        if (sel_irr) rd_isr_q <= 1'b0;
        if (sel_isr) rd_isr_q <= 1'b1;
        if (data_wr) begin
          case (state_q)
            CFG_WAIT_BASE: begin
              base_q  <= bus_wdata[DW-1:IDX_W];
              state_q <= CFG_WAIT_CASC;
            end
            CFG_WAIT_CASC: begin
              casc_q  <= bus_wdata;
              state_q <= CFG_WAIT_MODE;
            end
            CFG_WAIT_MODE: begin
              aeoi_q  <= bus_wdata[MODE_AEOI_BIT];
              state_q <= CFG_READY;
            end
            default: mask_q <= bus_wdata[LINES-1:0];
          endcase
        end
      end
    end
  end

  // configuration words never reach the mask
  assert_init_keeps_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && state_q != CFG_READY) |=> $stable(mask_q));
endmodule

// File: rtl/pvic_req.sv
module pvic_req
  import pvic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic [LINES-1:0] trig,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [LINES-1:0] irr
);
  logic [LINES-1:0] prev_q, edge_q, rise, clr_vec;

  assign rise    = irq_in & ~prev_q;
  assign clr_vec = clr_valid ? line_bit(clr_idx) : '0;
  assign irr     = (irq_in & trig) | edge_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= irq_in;
      edge_q <= ((edge_q & ~clr_vec) | rise) & ~trig;
    end
  end

  // an edge-line request with no rise and no clear holds its value
  assert_edge_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_valid && rise == '0 && trig == '0) |=> (edge_q == $past(edge_q)));
endmodule

// File: rtl/pvic_prio.sv
module pvic_prio
  import pvic_pkg::*;
(
  input  logic [LINES-1:0] irr,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] isr,
  output logic             grant,
  output logic [IDX_W-1:0] win_idx
);
  pick_t pick;

  always_comb begin
    pick    = pick_first(irr & ~mask);
    win_idx = pick.idx;
    grant   = pick.hit && outranks(pick.idx, isr);
  end
endmodule

// File: rtl/pvic_isr.sv
module pvic_isr
  import pvic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  input  logic              grant,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              aeoi,
  input  logic              eoi_valid,
  input  logic [IDX_W-1:0]  eoi_idx,
  input  logic              init_clr,
  input  logic [BASE_W-1:0] base,
  output logic [LINES-1:0]  isr_q,
  output logic [DW-1:0]     vec_q,
  output logic              take
);
  logic [LINES-1:0] set_vec, clr_vec;

  assign take    = ack && grant;
  assign set_vec = (take && !aeoi) ? line_bit(win_idx) : '0;
  assign clr_vec = eoi_valid ? line_bit(eoi_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      vec_q <= '0;
    end else begin
      isr_q <= init_clr ? '0 : ((isr_q & ~clr_vec) | set_vec);
      if (ack) vec_q <= make_vector(base, grant ? win_idx : SPUR_IDX);
    end
  end

  assert_ack_sets_isr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !aeoi && !init_clr) |=> isr_q[$past(win_idx)]);

  assert_aeoi_no_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && aeoi) |=> ((isr_q & ~$past(isr_q)) == '0));

  assert_eoi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !take) |=> !isr_q[$past(eoi_idx)]);

  assert_spurious_vec_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !grant) |=> (vec_q[IDX_W-1:0] == SPUR_IDX && (isr_q & ~$past(isr_q)) == '0));
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              ack,
  input  logic              is_slave,
  output logic              int_out,
  output logic [DW-1:0]     vec_out,
  output logic [LINES-1:0]  casc_mask,
  output logic [IDX_W-1:0]  slave_id
);
  logic [LINES-1:0]  mask_q, trig_q, irr, isr_q;
  logic [BASE_W-1:0] base_q;
  logic [DW-1:0]     casc_q;
  logic              aeoi_q, rd_isr_q, eoi_valid, init_start, grant, take;
  logic [IDX_W-1:0]  eoi_idx, win_idx;

  pvic_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mask_q(mask_q), .base_q(base_q), .casc_q(casc_q),
    .aeoi_q(aeoi_q), .rd_isr_q(rd_isr_q), .trig_q(trig_q),
    .eoi_valid(eoi_valid), .eoi_idx(eoi_idx), .init_start(init_start)
  );

  pvic_req u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig(trig_q),
    .clr_valid(take), .clr_idx(win_idx), .irr(irr)
  );

  pvic_prio u_prio (
    .irr(irr), .mask(mask_q), .isr(isr_q), .grant(grant), .win_idx(win_idx)
  );

  pvic_isr u_isr (
    .clk(clk), .rst_n(rst_n), .ack(ack), .grant(grant), .win_idx(win_idx),
    .aeoi(aeoi_q), .eoi_valid(eoi_valid), .eoi_idx(eoi_idx),
    .init_clr(init_start), .base(base_q), .isr_q(isr_q), .vec_q(vec_q_w),
    .take(take)
  );

  logic [DW-1:0] vec_q_w;
  assign vec_out = vec_q_w;
  assign int_out = grant;

  assign casc_mask = is_slave ? '0 : casc_q[LINES-1:0];
  assign slave_id  = is_slave ? casc_q[IDX_W-1:0] : '0;

  always_comb begin
    case (bus_addr)
      ADDR_CMD:  bus_rdata = rd_isr_q ? isr_q : irr;
      ADDR_DATA: bus_rdata = mask_q;
      ADDR_TRIG: bus_rdata = trig_q;
      default:   bus_rdata = '0;
    endcase
  end

  // the interrupt output needs an unmasked request behind it
  assert_int_needs_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask_q) != '0));
endmodule

// File: tb/pvic_top_bench.sv
module pvic_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ack = 1'b0;
  logic       is_slave = 1'b0;
  logic       int_out;
  logic [7:0] vec_out;
  logic [7:0] casc_mask;
  logic [2:0] slave_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pvic_top u_pvic_top (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack(ack), .is_slave(is_slave), .int_out(int_out), .vec_out(vec_out),
    .casc_mask(casc_mask), .slave_id(slave_id)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
    bus_addr = 2'd0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic do_ack;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  function automatic int first_idx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic model_int(input logic [7:0] irr, input logic [7:0] msk,
                                     input logic [7:0] isr);
    int w;
    w = first_idx(irr & ~msk);
    if (w == 8) return 1'b0;
    for (int i = 0; i <= w; i++) if (isr[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk_int(input string req, input logic exp);
    #1 chk(req, {7'd0, int_out}, {7'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] m_prev, m_edge, m_isr, m_irr, exp_vec;
    logic [7:0] b_trig, b_mask;
    logic       pend_vec, m_g, a, e;
    int         w, ew;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 irr after reset", v, 8'h00);
    rd(2'd1, v); chk("R1 mask after reset", v, 8'hFF);
    rd(2'd2, v); chk("R1 trigger after reset", v, 8'h00);
    chk("R1 vec after reset", vec_out, 8'h00);
    chk_int("R1 int low after reset", 1'b0);
    wr(2'd0, 8'h0B); rd(2'd0, v); chk("R1 isr after reset", v, 8'h00);
    wr(2'd0, 8'h0A);

    // R2 configuration sequence, R4 master cascade
    wr(2'd0, 8'h11); wr(2'd1, 8'h20); wr(2'd1, 8'h04); wr(2'd1, 8'h01);
    rd(2'd1, v); chk("R2 mask untouched by config", v, 8'hFF);
    #1 chk("R4 master casc_mask", casc_mask, 8'h04);
    chk("R4 master slave_id", {5'd0, slave_id}, 8'h00);
    wr(2'd2, 8'h50);
    rd(2'd2, v); chk("R7 trigger readback", v, 8'h50);

    // R8 masked edge request recorded but no interrupt
    set_irq(8'h08);
    chk_int("R8 masked line no int", 1'b0);
    rd(2'd0, v); chk("R9 edge latched in irr", v, 8'h08);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R7 mask readback", v, 8'h00);
    chk_int("R8 unmasked raises int", 1'b1);
    do_ack;
    chk("R3 vector line3", vec_out, 8'h23);
    chk_int("R10 in-service blocks same line", 1'b0);
    wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R11 isr after ack", v, 8'h08);

    // R10 priority against in-service
    set_irq(8'h28);
    chk_int("R10 lower line blocked", 1'b0);
    set_irq(8'h2A);
    chk_int("R10 higher line outranks", 1'b1);
    do_ack;
    chk("R3 vector line1", vec_out, 8'h21);
    rd(2'd0, v); chk("R7 isr select persists", v, 8'h0A);

    // R6 specific EOI
    wr(2'd0, 8'h61);
    rd(2'd0, v); chk("R6 eoi line1 only", v, 8'h08);
    chk_int("R10 line5 still blocked", 1'b0);
    wr(2'd0, 8'h63);
    rd(2'd0, v); chk("R6 eoi line3", v, 8'h00);
    chk_int("R10 line5 now wins", 1'b1);
    wr(2'd0, 8'h0A);
    rd(2'd0, v); chk("R11 acked edge latches cleared", v, 8'h20);
    do_ack;
    chk("R3 vector line5", vec_out, 8'h25);
    wr(2'd0, 8'h65);
    chk_int("R9 held edge line gives no new request", 1'b0);
    set_irq(8'h00);

    // R12 spurious vector
    set_irq(8'h40);
    chk_int("R9 level line raises int", 1'b1);
    set_irq(8'h00);
    chk_int("R9 level line dropped", 1'b0);
    do_ack;
    chk("R12 spurious vector", vec_out, 8'h27);
    wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R12 isr unchanged", v, 8'h00);

    // R9 level line re-requests after EOI
    set_irq(8'h10);
    do_ack;
    chk("R3 vector line4", vec_out, 8'h24);
    chk_int("R10 line4 in service", 1'b0);
    wr(2'd0, 8'h64);
    chk_int("R9 level still high re-requests", 1'b1);
    set_irq(8'h00);
    chk_int("R9 level released", 1'b0);

    // R2 re-config, R4 slave, R5 auto-EOI
    wr(2'd1, 8'hF0);
    is_slave = 1'b1;
    wr(2'd0, 8'h11); wr(2'd1, 8'h2B); wr(2'd1, 8'h02); wr(2'd1, 8'h03);
    #1 chk("R4 slave id", {5'd0, slave_id}, 8'h02);
    chk("R4 slave casc_mask zero", casc_mask, 8'h00);
    rd(2'd1, v); chk("R2 mask kept across config", v, 8'hF0);
    set_irq(8'h04);
    do_ack;
    chk("R2 new base in vector", vec_out, 8'h2A);
    wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R5 auto-eoi leaves isr clear", v, 8'h00);
    set_irq(8'h00);

    // random phase against a bench model
    rst_n = 1'b0; is_slave = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wr(2'd0, 8'h11); wr(2'd1, 8'h20); wr(2'd1, 8'h04); wr(2'd1, 8'h01);
    b_trig = 8'h5A; b_mask = 8'h21;
    wr(2'd2, b_trig); wr(2'd1, b_mask);
    m_prev = '0; m_edge = '0; m_isr = '0; pend_vec = 1'b0; exp_vec = '0;

    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      bus_wr = 1'b0; ack = 1'b0; bus_addr = 2'd0;
      if (pend_vec) chk("R3 R12 random vector", vec_out, exp_vec);
      if ($urandom % 3 == 0) irq_in = irq_in ^ (8'd1 << ($urandom % 8));
      a = ($urandom % 5 == 0);
      e = !a && (m_isr != 0) && ($urandom % 3 == 0);
      ew = first_idx(m_isr);
      if (e) begin
        bus_wr = 1'b1; bus_wdata = 8'h60 + 8'(ew);
      end
      ack = a;
      m_irr = (irq_in & b_trig) | m_edge;
      m_g = model_int(m_irr, b_mask, m_isr);
      w = first_idx(m_irr & ~b_mask);
      #1;
      chk("R10 random int", {7'd0, int_out}, {7'd0, m_g});
      chk("R9 random irr readback", bus_rdata, m_irr);
      @(posedge clk);
      if (a && m_g) m_edge = m_edge & ~(8'd1 << w);
      m_edge = (m_edge | (irq_in & ~m_prev)) & ~b_trig;
      m_prev = irq_in;
      if (e) m_isr = m_isr & ~(8'd1 << ew);
      if (a && m_g) m_isr = m_isr | (8'd1 << w);
      exp_vec = {5'h04, (a && m_g) ? 3'(w) : 3'd7};
      pend_vec = a;
    end
    @(negedge clk);
    bus_wr = 1'b0; ack = 1'b0;
    if (pend_vec) chk("R11 final random vector", vec_out, exp_vec);
    wr(2'd0, 8'h0B);
    rd(2'd0, v); chk("R11 R6 random isr", v, m_isr);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule